// File: doc/BRIEF.md
# BCD Seven-Segment Display Chain with Zero Blanking

This block drives a row of seven-segment digits from packed 4-bit BCD codes. Each digit is decoded into seven active-low segment signals. Codes 10 to 15 map to fixed non-numeric glyphs, and code 15 shows nothing. A lamp-test input lights every segment. A forced-blank path turns every segment off, and a ripple zero-blanking chain hides zero digits that run in from one end of the row. One control bit picks the end: leading zeros run in from the most significant digit, trailing zeros from the least significant one.

The forced-blank path is driven inside the block by a dimmer. A free-running counter is compared against a brightness level, so the display is lit in a fixed fraction of every counter period. Segment outputs and the chain's ripple output are registered. Each therefore follows its inputs one clock later. The ripple input and output let several of these blocks be cascaded into a longer chain.

Top module: `seg_display_chain`

## Requirements
- R1: With ripple input high, lamp test high and full brightness, each code 0 to 9 shows its digit one clock after it is applied. Segment outputs are active low (0 = lit). Digit i uses seg_n_o[7i+6:7i], with bit 0 = a, bit 1 = b, up to bit 6 = g. Digit 6 has segment a off, digit 7 lights only a, b and c, and digit 9 has segment d off.
- R2: Codes 10 to 15 light these segments: 10 lights d, e and g; 11 lights c, d and g; 12 lights b, f and g; 13 lights a, c, d, f and g; 14 lights d, e, f and g; 15 lights none.
- R3: Whenever the dimmer is in its off phase, every segment of every digit is dark one clock later. This holds whatever the data, lamp test and ripple inputs are.
- R4: With lamp test low (active) and the dimmer in its on phase, every segment of every digit is lit one clock later. This overrides the data and zero blanking.
- R5: With trail_i = 0 (leading mode), the ripple input enters at digit DIGITS-1 and passes toward digit 0. A digit is dark when its code is 0, its incoming ripple is low and lamp test is high, and only then does it pass a low ripple on.
- R6: With trail_i = 1 (trailing mode), the ripple input enters at digit 0 and passes toward digit DIGITS-1, with the same per-digit rule as R5.
- R7: With ripple_n_i high, no digit is zero-blanked: code 0 shows the digit 0, and ripple_n_o is high.
- R8: ripple_n_o is low, one clock later, exactly when ripple_n_i is low, lamp test is high and every digit's code is 0. It does not depend on the dimmer.
- R9: With brightness_i = B, the display is lit in exactly min(B, 256) cycles of any 256 consecutive cycles. B = 0 keeps it dark, and B = 256 keeps it always lit.
- R10: During reset, every segment is dark and ripple_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcd_i | input | 4*DIGITS | Packed codes, digit i at bits 4i+3:4i |
| trail_i | input | 1 | 0 = leading-zero chain, 1 = trailing-zero chain |
| ripple_n_i | input | 1 | Ripple blanking into the first digit of the chain (active low) |
| lamp_test_n_i | input | 1 | Lamp test (active low) |
| brightness_i | input | BRIGHT_W+1 | On-cycles per 2^BRIGHT_W cycle period |
| seg_n_o | output | 7*DIGITS | Registered active-low segments |
| ripple_n_o | output | 1 | Registered ripple blanking out of the last digit of the chain |

## Verification
A fault in the ripple chain shows at the ports one clock after the data is applied. A zero digit is then lit where it should be dark, or a dark digit appears beyond the first nonzero code. ripple_n_o exposes the state at the end of the chain in the same cycle. A dimmer counter that skips or sticks cannot be seen in any single cycle. It shows only as a wrong count of lit cycles over one full 256-cycle period, so the duty checks count across a whole period.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEG_N  = 7;
    localparam int CODE_N = 4;

    typedef logic [SEG_N-1:0]  seg_t;
    typedef logic [CODE_N-1:0] code_t;

    // Lit-segment mask, active high, bit 0 = a .. bit 6 = g
    function automatic seg_t glyph_lit(input code_t code);
        seg_t m;
        case (code)
            4'd0:    m = 7'h3F;
            4'd1:    m = 7'h06;
            4'd2:    m = 7'h5B;
            4'd3:    m = 7'h4F;
            4'd4:    m = 7'h66;
            4'd5:    m = 7'h6D;
            4'd6:    m = 7'h7C;
            4'd7:    m = 7'h07;
            4'd8:    m = 7'h7F;
            4'd9:    m = 7'h67;
            4'd10:   m = 7'h58;
            4'd11:   m = 7'h4C;
            4'd12:   m = 7'h62;
            4'd13:   m = 7'h6D;
            4'd14:   m = 7'h78;
            default: m = 7'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/seg_dimmer.sv
module seg_dimmer #(
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CNT_W:0] level_i,
    output logic           on_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dim_t;

    dim_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = {1'b0, st_q.cnt} < level_i;

    // R9: the phase counter advances by exactly one every cycle
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R9: level zero never enables the display
    p_zero_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == '0) |-> !on_o);

endmodule

// File: rtl/seg_zero_chain.sv
module seg_zero_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] zero_i,
    input  logic         lt_n_i,
    input  logic         trail_i,
    input  logic         ripple_n_i,
    output logic [N-1:0] rbi_n_o,
    output logic         ripple_n_o
);
    logic         carry_n;
    logic [N-1:0] rbi_n;

    // A digit passes a low ripple on only when it is itself zero-blanked
    always_comb begin
        carry_n = ripple_n_i;
        rbi_n   = '1;
        if (trail_i) begin
            for (int i = 0; i < N; i++) begin
                rbi_n[i] = carry_n;
                carry_n  = carry_n | ~zero_i[i] | ~lt_n_i;
            end
        end else begin
            for (int i = N-1; i >= 0; i--) begin
                rbi_n[i] = carry_n;
                carry_n  = carry_n | ~zero_i[i] | ~lt_n_i;
            end
        end
    end

    assign rbi_n_o    = rbi_n;
    assign ripple_n_o = carry_n;

endmodule

// File: rtl/seg_digit_decoder.sv
module seg_digit_decoder
    import seg_pkg::*;
(
    input  code_t code_i,
    input  logic  rbi_n_i,
    input  logic  bi_n_i,
    input  logic  lt_n_i,
    output seg_t  seg_n_o
);
    // Priority: forced blank, then lamp test, then zero blank, then glyph
    always_comb begin
        if (!bi_n_i)                          seg_n_o = '1;
        else if (!lt_n_i)                     seg_n_o = '0;
        else if (!rbi_n_i && code_i == '0)    seg_n_o = '1;
        else                                  seg_n_o = ~glyph_lit(code_i);
    end

endmodule

// File: rtl/seg_display_chain.sv
module seg_display_chain
    import seg_pkg::*;
#(
    parameter int DIGITS   = 4,
    parameter int BRIGHT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CODE_N*DIGITS-1:0]   bcd_i,
    input  logic                       trail_i,
    input  logic                       ripple_n_i,
    input  logic                       lamp_test_n_i,
    input  logic [BRIGHT_W:0]          brightness_i,
    output logic [SEG_N*DIGITS-1:0]    seg_n_o,
    output logic                       ripple_n_o
);
    localparam int SEG_BITS = SEG_N * DIGITS;

    typedef struct packed {
        logic [SEG_BITS-1:0] seg_n;
        logic                ripple_n;
    } out_t;

    out_t st_d, st_q;

    logic                dim_on;
    logic [DIGITS-1:0]   zero;
    logic [DIGITS-1:0]   rbi_n;
    logic                chain_out_n;
    logic [SEG_BITS-1:0] seg_comb;

    seg_dimmer #(.CNT_W(BRIGHT_W)) u_dimmer (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (brightness_i),
        .on_o    (dim_on)
    );

    generate
        for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
            assign zero[gi] = bcd_i[CODE_N*gi +: CODE_N] == '0;

            seg_digit_decoder u_dec (
                .code_i  (bcd_i[CODE_N*gi +: CODE_N]),
                .rbi_n_i (rbi_n[gi]),
                .bi_n_i  (dim_on),
                .lt_n_i  (lamp_test_n_i),
                .seg_n_o (seg_comb[SEG_N*gi +: SEG_N])
            );
        end
    endgenerate

    seg_zero_chain #(.N(DIGITS)) u_chain (
        .zero_i     (zero),
        .lt_n_i     (lamp_test_n_i),
        .trail_i    (trail_i),
        .ripple_n_i (ripple_n_i),
        .rbi_n_o    (rbi_n),
        .ripple_n_o (chain_out_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.seg_n    = seg_comb;
        st_d.ripple_n = chain_out_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seg_n    <= '1;
            st_q.ripple_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_n_o    = st_q.seg_n;
    assign ripple_n_o = st_q.ripple_n;

    // R3: an off phase of the dimmer darkens the whole row next cycle
    p_dim_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dim_on |=> seg_n_o == '1);

    // R4: lamp test in an on phase lights every segment next cycle
    p_lamp_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_on && !lamp_test_n_i) |=> seg_n_o == '0);

    // R7: a high ripple input can never produce a low ripple output
    p_ripple_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ripple_n_i |=> ripple_n_o);

    // R8: lamp test stops the ripple from reaching the output
    p_ripple_lamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_test_n_i |=> ripple_n_o);

endmodule

// File: tb/tb_seg_display_chain.sv
`timescale 1ns/1ps
module tb_seg_display_chain;

    localparam int ND = 4;
    localparam logic [6:0] SA = 7'h01, SB = 7'h02, SC = 7'h04, SD = 7'h08,
                           SE = 7'h10, SF = 7'h20, SG = 7'h40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*ND-1:0] bcd = '0;
    logic            trail = 1'b0;
    logic            rin_n = 1'b1;
    logic            lt_n = 1'b1;
    logic [8:0]      bright = 9'd256;
    logic [7*ND-1:0] seg_n;
    logic            rout_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_display_chain #(.DIGITS(ND), .BRIGHT_W(8)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bcd_i         (bcd),
        .trail_i       (trail),
        .ripple_n_i    (rin_n),
        .lamp_test_n_i (lt_n),
        .brightness_i  (bright),
        .seg_n_o       (seg_n),
        .ripple_n_o    (rout_n)
    );

    function automatic logic [6:0] lit_of(input logic [3:0] c);
        case (c)
            4'd0:  return SA|SB|SC|SD|SE|SF;
            4'd1:  return SB|SC;
            4'd2:  return SA|SB|SD|SE|SG;
            4'd3:  return SA|SB|SC|SD|SG;
            4'd4:  return SB|SC|SF|SG;
            4'd5:  return SA|SC|SD|SF|SG;
            4'd6:  return SC|SD|SE|SF|SG;
            4'd7:  return SA|SB|SC;
            4'd8:  return SA|SB|SC|SD|SE|SF|SG;
            4'd9:  return SA|SB|SC|SF|SG;
            4'd10: return SD|SE|SG;
            4'd11: return SC|SD|SG;
            4'd12: return SB|SF|SG;
            4'd13: return SA|SC|SD|SF|SG;
            4'd14: return SD|SE|SF|SG;
            default: return 7'h00;
        endcase
    endfunction

    // Expected segments at full brightness, built from R1, R2, R4-R7
    function automatic logic [7*ND-1:0] exp_row(input logic [4*ND-1:0] b,
                                                input logic tr, input logic ri_n,
                                                input logic l_n);
        logic [7*ND-1:0] r;
        for (int i = 0; i < ND; i++) begin
            bit run = 1'b1;
            for (int j = 0; j < ND; j++) begin
                if ((tr && j <= i) || (!tr && j >= i))
                    if (b[4*j +: 4] != 4'd0) run = 1'b0;
            end
            if (!l_n)                r[7*i +: 7] = 7'h00;
            else if (!ri_n && run)   r[7*i +: 7] = 7'h7F;
            else                     r[7*i +: 7] = ~lit_of(b[4*i +: 4]);
        end
        return r;
    endfunction

    function automatic logic exp_rout(input logic [4*ND-1:0] b,
                                      input logic ri_n, input logic l_n);
        return !(!ri_n && l_n && b == '0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, sample one rising edge later
    task automatic apply(input logic [4*ND-1:0] b, input logic tr,
                         input logic ri_n, input logic l_n);
        @(negedge clk);
        bcd = b; trail = tr; rin_n = ri_n; lt_n = l_n;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 segs in reset", 32'(seg_n), 32'(28'hFFFFFFF));
        chk("R10 ripple in reset", 32'(rout_n), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_digits();
        for (int c = 0; c < 10; c++) begin
            logic [4*ND-1:0] b = {ND{4'(c)}};
            apply(b, 1'b0, 1'b1, 1'b1);
            chk($sformatf("R1 digit %0d", c), 32'(seg_n), 32'(exp_row(b, 1'b0, 1'b1, 1'b1)));
        end
        apply(16'h6794, 1'b0, 1'b1, 1'b1);
        chk("R1 mixed positions", 32'(seg_n), 32'(exp_row(16'h6794, 1'b0, 1'b1, 1'b1)));
    endtask

    task automatic t_hex();
        for (int c = 10; c < 16; c++) begin
            logic [4*ND-1:0] b = {ND{4'(c)}};
            apply(b, 1'b0, 1'b1, 1'b1);
            chk($sformatf("R2 code %0d", c), 32'(seg_n), 32'(exp_row(b, 1'b0, 1'b1, 1'b1)));
        end
        apply(16'hF0AD, 1'b0, 1'b1, 1'b1);
        chk("R2 mixed glyphs", 32'(seg_n), 32'(exp_row(16'hF0AD, 1'b0, 1'b1, 1'b1)));
    endtask

    task automatic t_leading();
        apply(16'h0030, 1'b0, 1'b0, 1'b1);
        chk("R5 leading blank", 32'(seg_n), 32'(exp_row(16'h0030, 1'b0, 1'b0, 1'b1)));
        chk("R5 ripple stops", 32'(rout_n), 32'd1);
        apply(16'h0000, 1'b0, 1'b0, 1'b1);
        chk("R5 all zero dark", 32'(seg_n), 32'(28'hFFFFFFF));
        chk("R8 all zero ripple low", 32'(rout_n), 32'(exp_rout(16'h0000, 1'b0, 1'b1)));
        apply(16'h0501, 1'b0, 1'b0, 1'b1);
        chk("R5 inner zero kept", 32'(seg_n), 32'(exp_row(16'h0501, 1'b0, 1'b0, 1'b1)));
    endtask

    task automatic t_trailing();
        apply(16'h0300, 1'b1, 1'b0, 1'b1);
        chk("R6 trailing blank", 32'(seg_n), 32'(exp_row(16'h0300, 1'b1, 1'b0, 1'b1)));
        apply(16'h9000, 1'b1, 1'b0, 1'b1);
        chk("R6 three low zeros dark", 32'(seg_n), 32'(exp_row(16'h9000, 1'b1, 1'b0, 1'b1)));
        chk("R8 trailing ripple high", 32'(rout_n), 32'd1);
        apply(16'h0000, 1'b1, 1'b0, 1'b1);
        chk("R8 trailing ripple low", 32'(rout_n), 32'd0);
    endtask

    task automatic t_rin_high();
        apply(16'h0000, 1'b0, 1'b1, 1'b1);
        chk("R7 zeros shown", 32'(seg_n), 32'(exp_row(16'h0000, 1'b0, 1'b1, 1'b1)));
        chk("R7 ripple out high", 32'(rout_n), 32'd1);
    endtask

    task automatic t_lamp();
        apply(16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R4 lamp over zero blank", 32'(seg_n), 32'd0);
        chk("R8 lamp holds ripple high", 32'(rout_n), 32'd1);
        apply(16'hF0F0, 1'b1, 1'b1, 1'b0);
        chk("R4 lamp over blank glyph", 32'(seg_n), 32'd0);
    endtask

    task automatic t_blank();
        @(negedge clk);
        bright = 9'd0;
        apply(16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R3 blank over lamp", 32'(seg_n), 32'(28'hFFFFFFF));
        apply(16'h0000, 1'b0, 1'b0, 1'b1);
        chk("R8 ripple low while dark", 32'(rout_n), 32'd0);
        apply(16'h8888, 1'b0, 1'b1, 1'b1);
        chk("R3 blank over data", 32'(seg_n), 32'(28'hFFFFFFF));
    endtask

    task automatic t_dim(input int lvl);
        int lit = 0;
        @(negedge clk);
        bright = 9'(lvl);
        apply(16'h8888, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (seg_n != '1) lit++;
        end
        chk($sformatf("R9 lit cycles at level %0d", lvl), 32'(lit), 32'(lvl > 256 ? 256 : lvl));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_digits();
        t_hex();
        t_leading();
        t_trailing();
        t_rin_high();
        t_lamp();
        t_blank();
        t_dim(0);
        t_dim(1);
        t_dim(100);
        t_dim(256);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule